// File: doc/BRIEF.md
# Hardware Reset and Ready/Busy Controller

This block sits between a memory device's active-low hardware reset pin and its internal machinery: the embedded program/erase engine, the command decoder and the data output drivers. It decides whether a low level on the pin counts as a real reset. It does so by counting consecutive low samples. A pin that goes high again before the count is reached is treated as a glitch, and the block carries on as if nothing happened.

Once a reset qualifies, the block sends a single-cycle abort to the engine and turns off the data output enable. It refuses commands and runs an internal reset interval. That interval is long if the engine was busy at the moment of qualification and short if it was idle. After the interval, and once the pin has been high for long enough, reads are allowed again. At that point a single-cycle pulse puts the command state machine back into read-array mode.

The ready/busy output is open-drain style: `rb_pull_low` high means the line is pulled to 0 (busy). The reset pin is assumed to be synchronous to `clk` already. Parameters must satisfy `T_RP >= 2` and all other timing parameters `>= 1`.

Top module: `hwrst_ctrl`

## Requirements
- R1: After `rst_n` is released, with the pin high, the block is in normal operation. `engine_abort` and `csm_read_mode` are 0, `dq_oe` equals `!oe_n`, `rb_pull_low` follows `engine_busy`, and commands pass through.
- R2: When the pin is sampled low on `T_RP` consecutive clock edges, `engine_abort` goes to 1 in the cycle that follows the `T_RP`-th low sample.
- R3: A low pulse that covers fewer than `T_RP` edges causes no abort. During that pulse `dq_oe` and `rb_pull_low` keep following `oe_n` and `engine_busy`, and commands pass again as soon as the pin is high.
- R4: `engine_abort` is high for exactly one cycle per qualified reset.
- R5: If `engine_busy` was 1 on the qualifying edge, `rb_pull_low` stays 1 for exactly `T_READY_BUSY` cycles, counted from the abort cycle. This holds whatever `engine_busy` does during that time.
- R6: If `engine_busy` was 0 on the qualifying edge, `rb_pull_low` stays 0 and the internal reset lasts `T_READY_IDLE` cycles. With the pin already high, reads return one cycle after the interval ends.
- R7: `dq_oe` is 0 from the abort cycle until reads are permitted again.
- R8: `cmd_rd_ok` and `cmd_wr_ok` are 0 whenever the pin is low, and also throughout the internal reset and recovery, even with the pin high.
- R9: After the internal reset, reads become permitted on the clock edge that samples the pin high for the `T_RH`-th consecutive time. `dq_oe` is therefore still 0 for `T_RH-1` cycles after the pin rises.
- R10: `csm_read_mode` pulses high for exactly one cycle per qualified reset, in the first cycle in which reads are permitted again.
- R11: With `oe_n` high, `dq_oe` is 0 in every state.
- R12: Once the internal reset interval has ended, `rb_pull_low` is 0 while the block waits for the pin to be released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the block's registers |
| rst_pin_n | input | 1 | Hardware reset pin, active low, synchronous to clk |
| oe_n | input | 1 | Output enable request, active low |
| cmd_rd | input | 1 | Read command request |
| cmd_wr | input | 1 | Write command request |
| engine_busy | input | 1 | Embedded program/erase engine is running |
| engine_abort | output | 1 | One-cycle abort to the embedded engine |
| cmd_rd_ok | output | 1 | Read command forwarded to the command decoder |
| cmd_wr_ok | output | 1 | Write command forwarded to the command decoder |
| dq_oe | output | 1 | Data output driver enable (0 = high impedance) |
| rb_pull_low | output | 1 | Ready/busy open-drain pull-down (1 = busy) |
| csm_read_mode | output | 1 | One-cycle pulse returning the command state machine to read-array |

## Verification
The bench aims at the pulse-width boundary. A glitch of `T_RP-1` low samples must leave a busy engine untouched, while `T_RP` samples must abort it in the following cycle. A counter that is off by one would either abort on the glitch or delay the abort by a cycle.

It measures the busy interval with the engine dropping `engine_busy` as soon as it sees the abort. A design that kept following `engine_busy` would release ready/busy far too early. It also measures the idle interval, which a design that ignored the engine's state would stretch to the long value.

It holds the pin low well past the internal reset and then counts the cycles until `dq_oe` returns. It also issues commands while the pin is high but recovery is still running. A design that timed recovery from the start of reset, or that gated commands only by the pin level, would reopen too soon.

// File: rtl/hwrst_pkg.sv
package hwrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_QUALIFY   = 3'd1,
    ST_RESETTING = 3'd2,
    ST_RECOVER   = 3'd3,
    ST_READY     = 3'd4
  } rst_state_e;

  // Width needed to hold values 0..maxv.
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Length of the internal reset interval, chosen by engine activity.
  function automatic int unsigned reset_len(input logic busy,
                                            input int unsigned t_busy,
                                            input int unsigned t_idle);
    return busy ? t_busy : t_idle;
  endfunction

  // True on the sample that completes a qualified low pulse.
  function automatic logic pulse_qualified(input int unsigned lows_before,
                                           input int unsigned t_rp);
    return (lows_before + 1) == t_rp;
  endfunction

endpackage

// File: rtl/hwrst_satcnt.sv
module hwrst_satcnt #(
  parameter int unsigned MAX = 4,
  parameter int unsigned W   = hwrst_pkg::cnt_width(MAX)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] LIMIT = W'(MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hwrst_gate.sv
module hwrst_gate
  import hwrst_pkg::*;
(
  input  rst_state_e st,
  input  logic       pin_n,
  input  logic       oe_n,
  input  logic       cmd_rd,
  input  logic       cmd_wr,
  input  logic       engine_busy,
  input  logic       was_busy,
  output logic       dq_oe,
  output logic       cmd_rd_ok,
  output logic       cmd_wr_ok,
  output logic       rb_pull_low
);

  logic in_reset;

  always_comb begin
    in_reset  = (st == ST_RESETTING) || (st == ST_RECOVER);
    dq_oe     = !oe_n && !in_reset;
    cmd_rd_ok = cmd_rd && pin_n && !in_reset;
    cmd_wr_ok = cmd_wr && pin_n && !in_reset;
    case (st)
      ST_RESETTING: rb_pull_low = was_busy;
      ST_RECOVER:   rb_pull_low = 1'b0;
      default:      rb_pull_low = engine_busy;
    endcase
  end

endmodule

// File: rtl/hwrst_ctrl.sv
module hwrst_ctrl
  import hwrst_pkg::*;
#(
  parameter int unsigned T_RP         = 4,
  parameter int unsigned T_READY_BUSY = 24,
  parameter int unsigned T_READY_IDLE = 8,
  parameter int unsigned T_RH         = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin_n,
  input  logic oe_n,
  input  logic cmd_rd,
  input  logic cmd_wr,
  input  logic engine_busy,
  output logic engine_abort,
  output logic cmd_rd_ok,
  output logic cmd_wr_ok,
  output logic dq_oe,
  output logic rb_pull_low,
  output logic csm_read_mode
);

  localparam int unsigned DUR_MAX = max2(T_READY_BUSY, T_READY_IDLE);
  localparam int unsigned LO_W    = cnt_width(T_RP);
  localparam int unsigned HI_W    = cnt_width(T_RH);
  localparam int unsigned DUR_W   = cnt_width(DUR_MAX);

  rst_state_e state_q, state_d;
  logic       was_busy_q;
  logic       abort_q;

  logic [LO_W-1:0]  lo_cnt;
  logic [HI_W-1:0]  hi_cnt;
  logic [DUR_W-1:0] dur_cnt;

  // Named internal events, visible to the checker.
  logic [31:0] lows_seen, highs_seen, dur_elapsed;
  logic        ev_qualified, ev_glitch, ev_int_done, ev_reads_ok;

  hwrst_satcnt #(.MAX(T_RP), .W(LO_W)) u_lo_cnt (
    .clk(clk), .rst_n(rst_n), .clr(rst_pin_n), .inc(!rst_pin_n), .cnt(lo_cnt)
  );

  hwrst_satcnt #(.MAX(T_RH), .W(HI_W)) u_hi_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!rst_pin_n), .inc(rst_pin_n), .cnt(hi_cnt)
  );

  hwrst_satcnt #(.MAX(DUR_MAX), .W(DUR_W)) u_dur_cnt (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_RESETTING), .inc(1'b1), .cnt(dur_cnt)
  );

  always_comb begin
    lows_seen    = 32'(lo_cnt);
    highs_seen   = 32'(hi_cnt);
    dur_elapsed  = 32'(dur_cnt);
    ev_qualified = (state_q == ST_QUALIFY) && !rst_pin_n &&
                   pulse_qualified(lows_seen, T_RP);
    ev_glitch    = (state_q == ST_QUALIFY) && rst_pin_n;
    ev_int_done  = (state_q == ST_RESETTING) &&
                   ((dur_elapsed + 1) >= reset_len(was_busy_q, T_READY_BUSY, T_READY_IDLE));
    ev_reads_ok  = (state_q == ST_RECOVER) && rst_pin_n && ((highs_seen + 1) >= T_RH);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (!rst_pin_n) state_d = ST_QUALIFY;
      ST_QUALIFY:   begin
                      if (ev_glitch)         state_d = ST_IDLE;
                      else if (ev_qualified) state_d = ST_RESETTING;
                    end
      ST_RESETTING: if (ev_int_done) state_d = ST_RECOVER;
      ST_RECOVER:   if (ev_reads_ok) state_d = ST_READY;
      ST_READY:     state_d = rst_pin_n ? ST_IDLE : ST_QUALIFY;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      was_busy_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= ev_qualified;
      if (ev_qualified) was_busy_q <= engine_busy;
    end
  end

  hwrst_gate u_gate (
    .st          (state_q),
    .pin_n       (rst_pin_n),
    .oe_n        (oe_n),
    .cmd_rd      (cmd_rd),
    .cmd_wr      (cmd_wr),
    .engine_busy (engine_busy),
    .was_busy    (was_busy_q),
    .dq_oe       (dq_oe),
    .cmd_rd_ok   (cmd_rd_ok),
    .cmd_wr_ok   (cmd_wr_ok),
    .rb_pull_low (rb_pull_low)
  );

  assign engine_abort  = abort_q;
  assign csm_read_mode = (state_q == ST_READY);

endmodule

// File: rtl/hwrst_ctrl_chk.sv
module hwrst_ctrl_chk
  import hwrst_pkg::*;
#(
  parameter int unsigned T_READY_BUSY = 24,
  parameter int unsigned T_READY_IDLE = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_pin_n,
  input logic        oe_n,
  input rst_state_e  state_q,
  input logic        was_busy_q,
  input logic [31:0] dur_elapsed,
  input logic        engine_abort,
  input logic        cmd_rd_ok,
  input logic        cmd_wr_ok,
  input logic        dq_oe,
  input logic        rb_pull_low,
  input logic        csm_read_mode
);

  assert_abort_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    engine_abort |-> (state_q == ST_RESETTING) && ($past(state_q) == ST_QUALIFY));

  assert_glitch_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUALIFY) && rst_pin_n |=> (state_q == ST_IDLE) && !engine_abort);

  assert_abort_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    engine_abort |=> !engine_abort);

  assert_rb_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESETTING) |-> (rb_pull_low == was_busy_q));

  assert_reset_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESETTING) |->
      (dur_elapsed < reset_len(was_busy_q, T_READY_BUSY, T_READY_IDLE)));

  assert_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RESETTING) || (state_q == ST_RECOVER)) |-> !dq_oe);

  assert_cmd_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |-> !cmd_rd_ok && !cmd_wr_ok);

  assert_ready_after_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY) |-> rst_pin_n && $past(rst_pin_n));

  assert_csm_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csm_read_mode |=> !csm_read_mode);

  assert_oe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  assert_rb_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOVER) |-> !rb_pull_low);

endmodule

bind hwrst_ctrl hwrst_ctrl_chk #(
  .T_READY_BUSY (T_READY_BUSY),
  .T_READY_IDLE (T_READY_IDLE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_pin_n     (rst_pin_n),
  .oe_n          (oe_n),
  .state_q       (state_q),
  .was_busy_q    (was_busy_q),
  .dur_elapsed   (dur_elapsed),
  .engine_abort  (engine_abort),
  .cmd_rd_ok     (cmd_rd_ok),
  .cmd_wr_ok     (cmd_wr_ok),
  .dq_oe         (dq_oe),
  .rb_pull_low   (rb_pull_low),
  .csm_read_mode (csm_read_mode)
);

// File: tb/hwrst_ctrl_tb.sv
module hwrst_ctrl_tb;

  localparam int CLK_PERIOD   = 10;
  localparam int T_RP         = 4;
  localparam int T_READY_BUSY = 24;
  localparam int T_READY_IDLE = 8;
  localparam int T_RH         = 3;
  localparam int WATCHDOG     = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin_n = 1'b1;
  logic oe_n = 1'b0;
  logic cmd_rd = 1'b0;
  logic cmd_wr = 1'b0;
  logic engine_busy = 1'b0;
  logic engine_abort, cmd_rd_ok, cmd_wr_ok, dq_oe, rb_pull_low, csm_read_mode;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwrst_ctrl #(
    .T_RP(T_RP), .T_READY_BUSY(T_READY_BUSY), .T_READY_IDLE(T_READY_IDLE), .T_RH(T_RH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .oe_n(oe_n),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .engine_busy(engine_busy),
    .engine_abort(engine_abort), .cmd_rd_ok(cmd_rd_ok), .cmd_wr_ok(cmd_wr_ok),
    .dq_oe(dq_oe), .rb_pull_low(rb_pull_low), .csm_read_mode(csm_read_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // One clock: inputs change and outputs are sampled at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    cmd_rd = 1'b1;
    #1;
    chk_eq("R1 abort after reset", int'(engine_abort), 0);
    chk_eq("R1 csm pulse after reset", int'(csm_read_mode), 0);
    chk_eq("R1 dq_oe follows oe_n", int'(dq_oe), 1);
    chk_eq("R1 rb follows engine", int'(rb_pull_low), 0);
    chk_eq("R1 read forwarded", int'(cmd_rd_ok), 1);
    engine_busy = 1'b1;
    #1;
    chk_eq("R1 rb follows engine busy", int'(rb_pull_low), 1);
    engine_busy = 1'b0;
    cmd_rd = 1'b0;
  endtask

  task automatic t_oe_off();
    oe_n = 1'b1;
    step();
    chk_eq("R11 oe_n high disables outputs", int'(dq_oe), 0);
    oe_n = 1'b0;
    step();
  endtask

  task automatic t_short_pulse();
    engine_busy = 1'b1;
    cmd_rd = 1'b1;
    rst_pin_n = 1'b0;
    #1;
    chk_eq("R8 read blocked while pin low", int'(cmd_rd_ok), 0);
    for (int i = 1; i <= T_RP - 1; i++) begin
      step();
      chk_eq("R3 no abort on short pulse", int'(engine_abort), 0);
      chk_eq("R3 rb follows engine during glitch", int'(rb_pull_low), 1);
      chk_eq("R3 outputs stay enabled during glitch", int'(dq_oe), 1);
    end
    rst_pin_n = 1'b1;
    step();
    chk_eq("R3 no abort after glitch", int'(engine_abort), 0);
    chk_eq("R3 read forwarded after glitch", int'(cmd_rd_ok), 1);
    cmd_rd = 1'b0;
    engine_busy = 1'b0;
    step();
  endtask

  task automatic t_busy_reset();
    int rb_run = 0;
    int closed = 0;
    engine_busy = 1'b1;
    rst_pin_n = 1'b0;
    for (int i = 1; i < T_RP; i++) begin
      step();
      chk_eq("R2 no abort before T_RP samples", int'(engine_abort), 0);
    end
    step();
    chk_eq("R2 abort after T_RP samples", int'(engine_abort), 1);
    chk_eq("R7 outputs off in abort cycle", int'(dq_oe), 0);
    engine_busy = 1'b0;
    while (rb_pull_low && rb_run < 200) begin
      rb_run++;
      if (rb_run == 2) chk_eq("R4 abort lasts one cycle", int'(engine_abort), 0);
      step();
    end
    chk_eq("R5 busy interval length", rb_run, T_READY_BUSY);
    for (int i = 0; i < 5; i++) begin
      chk_eq("R12 rb released while pin held", int'(rb_pull_low), 0);
      chk_eq("R7 outputs off while pin held", int'(dq_oe), 0);
      step();
    end
    rst_pin_n = 1'b1;
    step();
    while (!dq_oe && closed < 200) begin
      closed++;
      step();
    end
    chk_eq("R9 cycles closed after pin rise", closed, T_RH - 1);
    chk_eq("R10 read-array pulse on reopen", int'(csm_read_mode), 1);
    step();
    chk_eq("R10 read-array pulse single", int'(csm_read_mode), 0);
  endtask

  task automatic t_idle_reset();
    int closed = 0;
    bit saw_rb = 1'b0;
    engine_busy = 1'b0;
    rst_pin_n = 1'b0;
    for (int i = 1; i <= T_RP; i++) step();
    chk_eq("R2 abort in idle case", int'(engine_abort), 1);
    rst_pin_n = 1'b1;
    cmd_wr = 1'b1;
    cmd_rd = 1'b1;
    #1;
    chk_eq("R8 write blocked in reset with pin high", int'(cmd_wr_ok), 0);
    chk_eq("R8 read blocked in reset with pin high", int'(cmd_rd_ok), 0);
    while (!dq_oe && closed < 200) begin
      closed++;
      if (rb_pull_low) saw_rb = 1'b1;
      step();
    end
    chk_eq("R6 idle reset window", closed, T_READY_IDLE + 1);
    chk_eq("R6 rb stays released in idle case", int'(saw_rb), 0);
    chk_eq("R10 read-array pulse idle case", int'(csm_read_mode), 1);
    chk_eq("R8 write forwarded after recovery", int'(cmd_wr_ok), 1);
    cmd_wr = 1'b0;
    cmd_rd = 1'b0;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_oe_off();
    t_short_pulse();
    t_busy_reset();
    t_idle_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule